// File: doc/BRIEF.md
# Stuck-At Line Fault Injector

This block sits in series with a bundle of digital lines, for example a memory data bus or a pair of serial transmit and receive wires. While no fault is active, every line passes straight through. When the block is armed, it forces the lines selected by a mask to one fixed logic level. The level is either 0 or 1 and is the same for all forced lines, so several lines can fail together as a common-mode fault. The forcing lasts for one of three persistence patterns: a single pulse of programmed length, a repeating train of pulses separated by a programmed gap, or a hold that lasts until the block is disarmed.

The start of forcing can wait for the target's memory-access strobe, so the fault lands on a chosen access without halting the target. A long pulse can span several strobes, which corrupts the same bit position in consecutive words. At the end of every pulse the block emits a one-cycle report. The report says whether the fault was effective, meaning that at least one forced line carried the opposite value at some point during the pulse. It also gives the number of strobes that occurred while forcing was applied. The configuration is captured when the block is armed. A configuration that cannot produce a fault is refused and flagged.

Top module: `stuck_fault_injector`

## Requirements
- R1: Out of reset `lineOut` equals `lineIn`, and `faultActive`, `done` and `cfgError` are 0. Whenever `faultActive` is 0, `lineOut` equals `lineIn`.
- R2: While `faultActive` is 1, each line whose mask bit is 1 drives `cfgValue` (0 or 1). Every line whose mask bit is 0 drives its `lineIn` value. Any number of mask bits may be set at once.
- R3: Transient mode (`cfgMode` = 0): a rising edge of `arm` sampled at a clock edge starts forcing in the next cycle. Forcing lasts exactly `cfgDuration` cycles and happens once per rising edge.
- R4: Intermittent mode (`cfgMode` = 1): the block forces for `cfgDuration` cycles, then releases for `cfgPeriod` cycles. This pattern repeats while `arm` stays high.
- R5: Permanent mode (`cfgMode` = 2): forcing starts in the cycle after the arm edge and holds until `arm` is sampled low. `cfgDuration` is ignored in this mode.
- R6: With `cfgSync` = 1, forcing begins in the cycle after the first `strobe` that is sampled high after the arm edge (transient and intermittent modes) or after the gap (intermittent mode). Until that strobe arrives, no line is forced.
- R7: `done` is high for exactly one cycle, the first cycle after each forcing pulse ends. In that cycle `effective` is 1 when any masked line differed from the stuck value in at least one forced cycle, and 0 otherwise.
- R8: The `strobeCount` reported with `done` equals the number of forced cycles in which `strobe` was sampled high.
- R9: A start is refused in three cases: `cfgMode` = 3, a zero `cfgDuration` in transient or intermittent mode, or a zero `cfgPeriod` in intermittent mode. When refused, `cfgError` becomes 1 in the next cycle and nothing is forced. The next start that is accepted clears `cfgError`.
- R10: `arm` sampled low ends forcing in the next cycle, and in that cycle `done` reports the shortened pulse. The mask, value, mode, duration, period and sync inputs are captured at the start, and changing them during a pulse has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgMask | input | NUM_LINES | Lines to force |
| cfgValue | input | 1 | Stuck level for the masked lines |
| cfgMode | input | 2 | 0 transient, 1 intermittent, 2 permanent, 3 invalid |
| cfgDuration | input | CNT_W | Length of each forcing pulse in cycles |
| cfgPeriod | input | CNT_W | Gap between intermittent pulses in cycles |
| cfgSync | input | 1 | Start each pulse on a strobe |
| arm | input | 1 | Rising edge starts an injection; low disarms |
| strobe | input | 1 | Target memory-access strobe |
| lineIn | input | NUM_LINES | Lines from the source |
| lineOut | output | NUM_LINES | Lines to the destination, possibly forced |
| faultActive | output | 1 | Forcing applied this cycle |
| done | output | 1 | One-cycle end-of-pulse report |
| effective | output | 1 | The reported pulse altered at least one line |
| strobeCount | output | STB_W | Strobes seen during the reported pulse |
| cfgError | output | 1 | Last start was refused |

## Verification
A wrong pulse counter shows up at the ports in the cycle where the pulse should have ended. `faultActive` and the forced lines either linger or drop early, and `done` moves by the same amount. A stale effectiveness or strobe accumulator shows up in the next `done` report, which differs from the bench's count of differing lines and strobes over the cycles it drove. A state machine stuck in its wait or gap state shows within one strobe or one gap length as a missing forced cycle. For these reasons the bench checks the lines every cycle across a sweep of masks, stuck levels and lengths, instead of only at pulse ends.

// File: rtl/sfi_pkg.sv
package sfi_pkg;

  typedef enum logic [1:0] {
    MODE_TRANSIENT    = 2'd0,
    MODE_INTERMITTENT = 2'd1,
    MODE_PERMANENT    = 2'd2,
    MODE_INVALID      = 2'd3
  } sfiMode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_FORCE,
    ST_GAP
  } sfiState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // accepted start: latch mask and value, clear accumulators
    logic active;   // forcing applied this cycle
    logic finish;   // last forced cycle of a pulse
  } sfiCtrl_t;

endpackage

// File: rtl/sfi_control.sv
module sfi_control
  import sfi_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       cfgMode,
  input  logic [CNT_W-1:0] cfgDuration,
  input  logic [CNT_W-1:0] cfgPeriod,
  input  logic             cfgSync,
  input  logic             arm,
  input  logic             strobe,
  output sfiCtrl_t         ctrl,
  output logic             cfgError
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  sfiState_e        state;
  sfiMode_e         modeQ;
  logic             armQ;
  logic             syncQ;
  logic [CNT_W-1:0] durQ;
  logic [CNT_W-1:0] perQ;
  logic [CNT_W-1:0] cnt;
  logic             armRise;
  logic             cfgBad;
  logic             lastCycle;

  assign armRise = arm && !armQ;
  assign cfgBad  = (cfgMode == MODE_INVALID) ||
                   ((cfgMode != MODE_PERMANENT) && (cfgDuration == '0)) ||
                   ((cfgMode == MODE_INTERMITTENT) && (cfgPeriod == '0));
  assign lastCycle = (modeQ != MODE_PERMANENT) && (cnt == ONE);

  assign ctrl.capture = (state == ST_IDLE) && armRise && !cfgBad;
  assign ctrl.active  = (state == ST_FORCE);
  assign ctrl.finish  = (state == ST_FORCE) && (!arm || lastCycle);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      modeQ    <= MODE_TRANSIENT;
      armQ     <= 1'b0;
      syncQ    <= 1'b0;
      durQ     <= '0;
      perQ     <= '0;
      cnt      <= '0;
      cfgError <= 1'b0;
    end else begin
      armQ <= arm;
      unique case (state)
        ST_IDLE: begin
          if (armRise) begin
            if (cfgBad) begin
              cfgError <= 1'b1;
            end else begin
              cfgError <= 1'b0;
              modeQ    <= sfiMode_e'(cfgMode);
              syncQ    <= cfgSync;
              durQ     <= cfgDuration;
              perQ     <= cfgPeriod;
              cnt      <= cfgDuration;
              state    <= cfgSync ? ST_WAIT : ST_FORCE;
            end
          end
        end
        ST_WAIT: begin
          if (!arm) begin
            state <= ST_IDLE;
          end else if (strobe) begin
            cnt   <= durQ;
            state <= ST_FORCE;
          end
        end
        ST_FORCE: begin
          if (!arm) begin
            state <= ST_IDLE;
          end else if (lastCycle) begin
            if (modeQ == MODE_INTERMITTENT) begin
              cnt   <= perQ;
              state <= ST_GAP;
            end else begin
              state <= ST_IDLE;
            end
          end else if (modeQ != MODE_PERMANENT) begin
            cnt <= cnt - ONE;
          end
        end
        ST_GAP: begin
          if (!arm) begin
            state <= ST_IDLE;
          end else if (cnt == ONE) begin
            cnt   <= durQ;
            state <= syncQ ? ST_WAIT : ST_FORCE;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_BAD_CFG_REFUSED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && armRise && cfgBad) |=> (cfgError && !ctrl.active)); // R9

  AST_FORCE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.active |-> $past(arm)); // R10

  AST_NO_FORCE_IN_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP && arm && cnt != ONE) |=> !ctrl.active); // R4

endmodule

// File: rtl/sfi_datapath.sv
module sfi_datapath
  import sfi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int STB_W     = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  sfiCtrl_t             ctrl,
  input  logic [NUM_LINES-1:0] cfgMask,
  input  logic                 cfgValue,
  input  logic [NUM_LINES-1:0] lineIn,
  input  logic                 strobe,
  output logic [NUM_LINES-1:0] lineOut,
  output logic                 done,
  output logic                 effective,
  output logic [STB_W-1:0]     strobeCount
);

  logic [NUM_LINES-1:0] maskQ;
  logic                 valueQ;
  logic [NUM_LINES-1:0] stuckVec;
  logic                 diffNow;
  logic                 diffAcc;
  logic [STB_W-1:0]     stbAcc;
  logic [STB_W-1:0]     stbNow;

  assign stuckVec = {NUM_LINES{valueQ}};

  generate
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      assign lineOut[g] = (ctrl.active && maskQ[g]) ? valueQ : lineIn[g];
    end
  endgenerate

  assign diffNow = |((lineIn ^ stuckVec) & maskQ);
  assign stbNow  = stbAcc + STB_W'(strobe);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ       <= '0;
      valueQ      <= 1'b0;
      diffAcc     <= 1'b0;
      stbAcc      <= '0;
      done        <= 1'b0;
      effective   <= 1'b0;
      strobeCount <= '0;
    end else begin
      done <= ctrl.finish;
      if (ctrl.capture) begin
        maskQ   <= cfgMask;
        valueQ  <= cfgValue;
        diffAcc <= 1'b0;
        stbAcc  <= '0;
      end else if (ctrl.finish) begin
        effective   <= diffAcc | diffNow;
        strobeCount <= stbNow;
        diffAcc     <= 1'b0;
        stbAcc      <= '0;
      end else if (ctrl.active) begin
        diffAcc <= diffAcc | diffNow;
        stbAcc  <= stbNow;
      end
    end
  end

  AST_FORCED_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.active |-> (((lineOut ^ stuckVec) & maskQ) == '0)); // R2

  AST_PASS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.active |-> (lineOut == lineIn)); // R1

  AST_DONE_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(ctrl.active) && !ctrl.active)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7

endmodule

// File: rtl/stuck_fault_injector.sv
module stuck_fault_injector
  import sfi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int CNT_W     = 32,
  parameter int STB_W     = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] cfgMask,
  input  logic                 cfgValue,
  input  logic [1:0]           cfgMode,
  input  logic [CNT_W-1:0]     cfgDuration,
  input  logic [CNT_W-1:0]     cfgPeriod,
  input  logic                 cfgSync,
  input  logic                 arm,
  input  logic                 strobe,
  input  logic [NUM_LINES-1:0] lineIn,
  output logic [NUM_LINES-1:0] lineOut,
  output logic                 faultActive,
  output logic                 done,
  output logic                 effective,
  output logic [STB_W-1:0]     strobeCount,
  output logic                 cfgError
);

  sfiCtrl_t ctrl;

  sfi_control #(.CNT_W(CNT_W)) control_i (
    .clk        (clk),
    .rstN       (rstN),
    .cfgMode    (cfgMode),
    .cfgDuration(cfgDuration),
    .cfgPeriod  (cfgPeriod),
    .cfgSync    (cfgSync),
    .arm        (arm),
    .strobe     (strobe),
    .ctrl       (ctrl),
    .cfgError   (cfgError)
  );

  sfi_datapath #(.NUM_LINES(NUM_LINES), .STB_W(STB_W)) datapath_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .cfgMask    (cfgMask),
    .cfgValue   (cfgValue),
    .lineIn     (lineIn),
    .strobe     (strobe),
    .lineOut    (lineOut),
    .done       (done),
    .effective  (effective),
    .strobeCount(strobeCount)
  );

  assign faultActive = ctrl.active;

endmodule

// File: tb/stuck_fault_injector_tb_top.sv
`timescale 1ns/1ps
module stuck_fault_injector_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  cfgMask = '0;
  logic        cfgValue = 1'b0;
  logic [1:0]  cfgMode = '0;
  logic [31:0] cfgDuration = '0;
  logic [31:0] cfgPeriod = '0;
  logic        cfgSync = 1'b0;
  logic        arm = 1'b0;
  logic        strobe = 1'b0;
  logic [7:0]  lineIn = '0;
  logic [7:0]  lineOut;
  logic        faultActive;
  logic        done;
  logic        effective;
  logic [15:0] strobeCount;
  logic        cfgError;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  stuck_fault_injector dut_i (
    .clk(clk), .rstN(rstN), .cfgMask(cfgMask), .cfgValue(cfgValue),
    .cfgMode(cfgMode), .cfgDuration(cfgDuration), .cfgPeriod(cfgPeriod),
    .cfgSync(cfgSync), .arm(arm), .strobe(strobe), .lineIn(lineIn),
    .lineOut(lineOut), .faultActive(faultActive), .done(done),
    .effective(effective), .strobeCount(strobeCount), .cfgError(cfgError)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] forced(input logic [7:0] lin, input logic [7:0] m, input logic v);
    return (lin & ~m) | ({8{v}} & m);
  endfunction

  task automatic setCfg(input logic [7:0] m, input logic v, input logic [1:0] md,
                        input int d, input int p, input logic s);
    cfgMask = m; cfgValue = v; cfgMode = md;
    cfgDuration = 32'(d); cfgPeriod = 32'(p); cfgSync = s;
  endtask

  // Transient pulse with per-cycle line checks and end report
  task automatic runTransient(input logic [7:0] m, input logic v, input int d, input int pat);
    logic [7:0] lin;
    logic effExp;
    int stbExp;
    effExp = 1'b0; stbExp = 0;
    @(negedge clk);
    setCfg(m, v, 2'd0, d, 0, 1'b0);
    arm = 1'b1;
    for (int i = 0; i < d; i++) begin
      @(negedge clk);
      lin = (pat == 1) ? {8{v}} : 8'(i * 53 + int'(m) + 17);
      lineIn = lin;
      strobe = (i % 2 == 0);
      cfgMask = ~m; cfgValue = ~v;   // R10: mid-pulse edits must not matter
      if (((lin ^ {8{v}}) & m) != 0) effExp = 1'b1;
      if (strobe) stbExp++;
      #1;
      chk(lineOut === forced(lin, m, v), "R2 forced lines", 32'(lineOut), 32'(forced(lin, m, v)));
      chk(faultActive === 1'b1, "R3 active during pulse", 32'(faultActive), 32'd1);
    end
    @(negedge clk);
    strobe = 1'b0; arm = 1'b0; lineIn = 8'h3C;
    #1;
    chk(faultActive === 1'b0 && lineOut === 8'h3C, "R3 pulse length", 32'(faultActive), 32'd0);
    chk(done === 1'b1, "R7 done after pulse", 32'(done), 32'd1);
    chk(effective === effExp, "R7 effective flag", 32'(effective), 32'(effExp));
    chk(strobeCount === 16'(stbExp), "R8 strobe count", 32'(strobeCount), 32'(stbExp));
    @(negedge clk);
    #1;
    chk(done === 1'b0 && faultActive === 1'b0, "R3 single pulse", 32'(done), 32'd0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    lineIn = 8'h5A;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(lineOut === 8'h5A && !faultActive && !done && !cfgError, "R1 reset state",
        32'({faultActive, done, cfgError}), 32'd0);

    // R2 R3 R7 R8 R10 sweep over masks, levels, lengths, line patterns
    for (int v = 0; v < 2; v++)
      for (int d = 1; d <= 3; d++)
        for (int mi = 0; mi < 3; mi++)
          for (int pat = 0; pat < 2; pat++)
            runTransient((mi == 0) ? 8'h01 : (mi == 1) ? 8'hA5 : 8'hFF, 1'(v), d, pat);

    // R4 intermittent: D on, P off, repeated
    for (int d = 1; d <= 2; d++)
      for (int p = 1; p <= 2; p++) begin
        int len;
        len = 2 * (d + p);
        @(negedge clk);
        setCfg(8'hFF, 1'b1, 2'd1, d, p, 1'b0);
        lineIn = 8'h00; arm = 1'b1;
        for (int c = 1; c <= len + 1; c++) begin
          logic actExp, doneExp;
          @(negedge clk);
          if (c == len + 1) arm = 1'b0;
          actExp = ((c - 1) % (d + p)) < d;
          doneExp = ((c - 1) % (d + p)) == d;
          #1;
          chk(faultActive === actExp, "R4 intermittent pattern", 32'(faultActive), 32'(actExp));
          chk(done === doneExp, "R4 intermittent done", 32'(done), 32'(doneExp));
        end
        @(negedge clk);
        #1;
        chk(done === 1'b1 && !faultActive, "R10 abort intermittent", 32'(done), 32'd1);
      end

    // R5 permanent held until disarm, ineffective because lines already 0
    @(negedge clk);
    setCfg(8'h0F, 1'b0, 2'd2, 0, 0, 1'b0);
    lineIn = 8'hF0; arm = 1'b1;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      #1;
      chk(faultActive === 1'b1 && lineOut === 8'hF0, "R5 permanent hold", 32'(lineOut), 32'hF0);
    end
    @(negedge clk);
    arm = 1'b0;
    #1;
    chk(faultActive === 1'b1, "R5 still held when arm drops", 32'(faultActive), 32'd1);
    @(negedge clk);
    #1;
    chk(!faultActive && done === 1'b1, "R5 release on disarm", 32'(done), 32'd1);
    chk(effective === 1'b0, "R7 ineffective fault", 32'(effective), 32'd0);

    // R6 strobe synchronised start
    @(negedge clk);
    setCfg(8'h80, 1'b1, 2'd0, 2, 0, 1'b1);
    lineIn = 8'h00; arm = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      #1;
      chk(!faultActive && lineOut === 8'h00, "R6 waits for strobe", 32'(faultActive), 32'd0);
    end
    @(negedge clk);
    strobe = 1'b1;
    #1;
    chk(!faultActive, "R6 not forced on strobe cycle", 32'(faultActive), 32'd0);
    for (int c = 0; c < 2; c++) begin
      @(negedge clk);
      strobe = 1'b0;
      #1;
      chk(faultActive === 1'b1 && lineOut === 8'h80, "R6 forced after strobe", 32'(lineOut), 32'h80);
    end
    @(negedge clk);
    arm = 1'b0;
    #1;
    chk(done === 1'b1 && strobeCount === 16'd0 && effective === 1'b1, "R8 trigger strobe not counted",
        32'(strobeCount), 32'd0);

    // R9 refused configurations
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (k == 0) setCfg(8'hFF, 1'b1, 2'd0, 0, 5, 1'b0);
      else if (k == 1) setCfg(8'hFF, 1'b1, 2'd1, 3, 0, 1'b0);
      else setCfg(8'hFF, 1'b1, 2'd3, 3, 3, 1'b0);
      arm = 1'b1; lineIn = 8'h00;
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        #1;
        chk(cfgError === 1'b1 && !faultActive && lineOut === 8'h00, "R9 refused start",
            32'({cfgError, faultActive}), 32'h2);
      end
      @(negedge clk);
      arm = 1'b0;
    end
    @(negedge clk);
    setCfg(8'h01, 1'b1, 2'd0, 1, 0, 1'b0);
    arm = 1'b1;
    @(negedge clk);
    #1;
    chk(cfgError === 1'b0 && faultActive === 1'b1, "R9 valid start clears error", 32'(cfgError), 32'd0);
    @(negedge clk);
    arm = 1'b0;

    // R10 abort of a long transient
    @(negedge clk);
    setCfg(8'h3C, 1'b0, 2'd0, 10, 0, 1'b0);
    lineIn = 8'hFF; arm = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      if (c == 2) arm = 1'b0;
      #1;
      chk(faultActive === 1'b1 && lineOut === 8'hC3, "R10 forced before abort", 32'(lineOut), 32'hC3);
    end
    @(negedge clk);
    #1;
    chk(!faultActive && done === 1'b1 && effective === 1'b1, "R10 abort ends pulse",
        32'({faultActive, done}), 32'h1);
    @(negedge clk);
    #1;
    chk(!faultActive && lineOut === 8'hFF, "R10 no restart without new edge", 32'(lineOut), 32'hFF);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule